// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a single-shot countdown timer driven from the core clock through a programmable power-of-two prescaler. Software selects the prescale ratio with a small divide code, then writes a 32-bit start value. That write arms the timer. The remaining count can be read back at any time. When the count runs out, a one-cycle expiry strobe is raised.

A free-running 7-bit phase counter sets the prescaler boundaries. It starts at zero on reset and advances once per core cycle. A start write that falls between two boundaries gets one extra prescaled period. This makes the expiry land on a prescaled edge. A second start write while the timer is running replaces the old countdown. A start value of zero stops the timer without an expiry.

Access is through a flat register port. Every cycle, the read data shows the register picked by the address. A write takes effect at the clock edge where the write strobe is high.

Top module: `ostmr_top`

## Requirements
- R1: After reset, every register reads zero and the expiry strobe is low. The registers are divide code at address 0, start value at address 1, remaining count at address 2, and an unused slot at address 3.
- R2: A write to address 0 keeps only bits 3, 1 and 0 of the data (mask 0xB). Reading address 0 returns the kept bits with bit 2 and all upper bits at zero. Writing 0xFFFFFFFF reads back as 0xB, and writing 0x4 reads back as 0.
- R3: The prescale ratio is 2 to the power ((({bit3,bit1,bit0} + 1) mod 8)). Code 7 (value 0xB) gives 1, code 0 gives 2, and code 6 (value 0xA) gives 128.
- R4: A write to address 1 stores all 32 data bits, and address 1 reads them back unchanged.
- R5: Take a nonzero start value N written at clock edge W, a ratio P, and o = (phase sampled at W) mod P. The phase is the number of clock edges since reset, modulo 128. The expiry strobe is high in the cycle after edge W+T, where T = N·P when o is 0 and T = N·P + (P − o) otherwise.
- R6: While running, address 2 reads ceil(R/P), where R is the number of clock edges still to come before the expiring edge. A value that would reach 2^32 reads as 0xFFFFFFFF.
- R7: Address 2 reads 0 when the timer is idle, including the cycle of the expiry strobe and every cycle after it.
- R8: Writes to address 2 (or 3) change no register and do not move the expiry time.
- R9: A nonzero start write while running cancels the old countdown. Expiry then follows R5, measured from the new write alone.
- R10: A start write of zero stops the timer at once. Address 2 then reads 0 and no expiry strobe follows.
- R11: The expiry strobe lasts exactly one cycle for each expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| reg_wr_i | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_addr_i | input | 2 | Register select for both reads and writes |
| reg_wdata_i | input | COUNT_W (32) | Write data |
| reg_rdata_o | output | COUNT_W (32) | Read data of the selected register |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
The bench builds the block with its default 32-bit count width. This makes the all-ones start value reachable, so the rounded-up readback can be checked at its saturation point. Because the divide encoding is fixed, all eight prescale ratios from 1 to 128 can be selected. The bench pairs each ratio with start writes at varying phase offsets, which covers both the aligned and the misaligned case. Start values are kept small so that even the 128 ratio expires within a short run.

// File: rtl/ostmr_pkg.sv
`timescale 1ns/1ps
package ostmr_pkg;
  // width of the packed divide code {cfg3, cfg1, cfg0}
  localparam int unsigned SHIFT_W = 3;
  // largest shift is 2**SHIFT_W - 1, so the phase needs that many bits
  localparam int unsigned PHASE_W = (1 << SHIFT_W) - 1;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIV    = 2'd0,
    SEL_START  = 2'd1,
    SEL_REMAIN = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  // code plus one, wrapping in SHIFT_W bits
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
    return code + {{(SHIFT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/ostmr_prescaler.sv
`timescale 1ns/1ps
module ostmr_prescaler
  import ostmr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W:0]   bnd;

  // bnd[s]: phase is a multiple of 2**s
  assign bnd[0] = 1'b1;
  for (genvar s = 1; s <= PHASE_W; s++) begin : g_bnd
    assign bnd[s] = (phase_q[s-1:0] == '0);
  end

  always_comb begin
    phase_d = phase_q + {{(PHASE_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign tick_o = bnd[shift_i];

  // R3: with a ratio above one, two boundaries are never adjacent
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && shift_i != '0) |=> (!tick_o || shift_i == '0));
endmodule

// File: rtl/ostmr_countdown.sv
`timescale 1ns/1ps
module ostmr_countdown #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [COUNT_W-1:0] load_val_i,
  output logic [COUNT_W-1:0] remain_o,
  output logic               expire_o
);
  localparam logic [COUNT_W:0] ONE = {{COUNT_W{1'b0}}, 1'b1};

  // one bit wider: a misaligned start holds start value plus one
  logic [COUNT_W:0] rem_q;
  logic [COUNT_W:0] rem_d;
  logic             rem_en;
  logic             exp_q;
  logic             exp_d;
  logic             running;

  assign running = (rem_q != '0);

  always_comb begin
    rem_d  = rem_q;
    exp_d  = 1'b0;
    rem_en = 1'b0;
    if (load_i) begin
      rem_en = 1'b1;
      if (load_val_i == '0) begin
        rem_d = '0;
      end else begin
        // off a boundary the partial period counts as one more unit
        rem_d = {1'b0, load_val_i} + {{COUNT_W{1'b0}}, ~tick_i};
      end
    end else if (tick_i && running) begin
      rem_en = 1'b1;
      rem_d  = rem_q - ONE;
      exp_d  = (rem_q == ONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (rem_en) begin
        rem_q <= rem_d;
      end
      exp_q <= exp_d;
    end
  end

  assign remain_o = rem_q[COUNT_W] ? {COUNT_W{1'b1}} : rem_q[COUNT_W-1:0];
  assign expire_o = exp_q;

  // R11: strobe never lasts two cycles
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  // R7: the strobe coincides with an empty count
  a_r7_idle_at_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (rem_q == '0));
  // R10: zero start empties the count and raises nothing
  a_r10_zero_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (rem_q == '0 && !expire_o));
  // R5: the count moves only on a prescaled boundary
  a_r5_hold_off_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(rem_q));
  // R6: without a start write the count never grows
  a_r6_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/ostmr_regfile.sv
`timescale 1ns/1ps
module ostmr_regfile
  import ostmr_pkg::*;
#(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [COUNT_W-1:0] wdata_i,
  input  logic [COUNT_W-1:0] remain_i,
  output logic [COUNT_W-1:0] rdata_o,
  output logic [SHIFT_W-1:0] code_o,
  output logic               load_o,
  output logic [COUNT_W-1:0] load_val_o
);
  reg_sel_e           sel;
  logic [SHIFT_W-1:0] code_q;
  logic [SHIFT_W-1:0] code_d;
  logic               code_en;
  logic [COUNT_W-1:0] start_q;
  logic [COUNT_W-1:0] start_d;
  logic               start_en;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    code_en  = wr_i && (sel == SEL_DIV);
    start_en = wr_i && (sel == SEL_START);
    // bit 2 of the written value is dropped
    code_d   = {wdata_i[3], wdata_i[1:0]};
    start_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      start_q <= '0;
    end else begin
      if (code_en) begin
        code_q <= code_d;
      end
      if (start_en) begin
        start_q <= start_d;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_DIV:    rdata_o = {{(COUNT_W-4){1'b0}}, code_q[2], 1'b0, code_q[1:0]};
      SEL_START:  rdata_o = start_q;
      SEL_REMAIN: rdata_o = remain_i;
      default:    rdata_o = '0;
    endcase
  end

  assign code_o     = code_q;
  assign load_o     = start_en;
  assign load_val_o = start_d;

  // R8: a write to the remaining-count slot leaves the stored registers alone
  a_r8_remain_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_REMAIN) |=> ($stable(code_q) && $stable(start_q)));
endmodule

// File: rtl/ostmr_top.sv
`timescale 1ns/1ps
module ostmr_top
  import ostmr_pkg::*;
#(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [COUNT_W-1:0] reg_wdata_i,
  output logic [COUNT_W-1:0] reg_rdata_o,
  output logic               expire_o
);
  logic [SHIFT_W-1:0] code;
  logic [SHIFT_W-1:0] shift;
  logic               tick;
  logic               load;
  logic [COUNT_W-1:0] load_val;
  logic [COUNT_W-1:0] remain;

  assign shift = code_to_shift(code);

  ostmr_regfile #(.COUNT_W(COUNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .remain_i   (remain),
    .rdata_o    (reg_rdata_o),
    .code_o     (code),
    .load_o     (load),
    .load_val_o (load_val)
  );

  ostmr_prescaler u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .tick_o  (tick)
  );

  ostmr_countdown #(.COUNT_W(COUNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (load_val),
    .remain_o   (remain),
    .expire_o   (expire_o)
  );
endmodule

// File: tb/ostmr_top_tb_top.sv
`timescale 1ns/1ps
module ostmr_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        expire;

  int n_vec;
  int n_bad;
  int cyc;
  bit done;

  ostmr_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .expire_o    (expire)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // clock edges since reset release: the phase count of R5
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int f_ratio(input logic [31:0] w);
    int code;
    code = (int'(w[3]) << 2) | int'(w[1:0]);
    return 1 << ((code + 1) % 8);
  endfunction

  function automatic int f_total(input int n, input int p, input int o);
    int om;
    om = o % p;
    return n * p + ((om == 0) ? 0 : (p - om));
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic start_count(input logic [31:0] v, output int o);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = v;
    o = cyc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // k counts falling edges after the start write edge
  task automatic measure(input int k0, input int t, input int p, input int kread, input string tag);
    int k;
    logic [31:0] v;
    k = k0;
    while (1) begin
      if (k == kread) begin
        rd(2'd2, v);
        chk({"R6 remaining ", tag}, v, ceil_div(t - k, p));
      end
      if (expire || k > t + 4) break;
      @(negedge clk);
      k++;
    end
    chk({"R5 expiry time ", tag}, k, t);
    @(negedge clk);
    chk({"R11 strobe width ", tag}, expire, 1'b0);
    rd(2'd2, v);
    chk({"R7 idle readback ", tag}, v, 0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] w;
    int p, o, t, o2, t2, n, hits, kr, seed;
    n_vec = 0; n_bad = 0; done = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    seed = $urandom(32'h5eed1234);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 div after reset", v, 0);
    rd(2'd1, v); chk("R1 start after reset", v, 0);
    rd(2'd2, v); chk("R1 remain after reset", v, 0);
    rd(2'd3, v); chk("R1 spare after reset", v, 0);
    chk("R1 strobe after reset", expire, 1'b0);

    // R2 masking
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 mask all ones", v, 32'hB);
    wr_reg(2'd0, 32'h4);
    rd(2'd0, v); chk("R2 bit2 dropped", v, 32'h0);

    // R3 every divide code, start value 3
    for (int c = 0; c < 8; c++) begin
      w = ((c >> 2) & 1) << 3 | (c & 3);
      wr_reg(2'd0, w);
      p = f_ratio(w);
      idle(c % 4);
      start_count(32'd3, o);
      t = f_total(3, p, o);
      measure(0, t, p, 0, $sformatf("R3 code %0d", c));
    end

    // constrained random trials
    for (int i = 0; i < 16; i++) begin
      w = $urandom & 32'hF;
      n = 1 + ($urandom % 12);
      wr_reg(2'd0, w);
      p = f_ratio(w);
      idle($urandom % 5);
      start_count(n, o);
      t = f_total(n, p, o);
      kr = $urandom % t;
      measure(0, t, p, kr, $sformatf("rand %0d", i));
    end

    // R8 writes to remaining-count ignored; ratio 4
    wr_reg(2'd0, 32'h1);
    start_count(32'd5, o);
    t = f_total(5, 4, o);
    wr_reg(2'd2, 32'h77);
    rd(2'd2, v); chk("R8 remain after poke", v, ceil_div(t - 1, 4));
    rd(2'd1, v); chk("R8 start unchanged", v, 5);
    rd(2'd0, v); chk("R8 div unchanged", v, 32'h1);
    measure(1, t, 4, -1, "R8");

    // R9 restart while running; ratio 2
    wr_reg(2'd0, 32'h0);
    start_count(32'd10, o);
    idle(5);
    chk("R9 no early strobe", expire, 1'b0);
    start_count(32'd4, o2);
    t2 = f_total(4, 2, o2);
    measure(0, t2, 2, 0, "R9 restart");

    // R10 zero start stops; ratio 8
    wr_reg(2'd0, 32'h2);
    start_count(32'd6, o);
    idle(10);
    start_count(32'd0, o);
    rd(2'd2, v); chk("R10 remain after stop", v, 0);
    hits = 0;
    for (int j = 0; j < 120; j++) begin
      @(negedge clk);
      if (expire) hits++;
    end
    chk("R10 no strobe after stop", hits, 0);

    // R6 saturation and R4 full-width storage; ratio 2, misaligned
    wr_reg(2'd0, 32'h0);
    if (cyc % 2 == 0) @(negedge clk);
    start_count(32'hFFFF_FFFF, o);
    chk("R6 misaligned phase", o % 2, 1);
    rd(2'd2, v); chk("R6 saturated readback", v, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R4 all ones stored", v, 32'hFFFF_FFFF);
    start_count(32'hA5C3_0F96, o);
    rd(2'd1, v); chk("R4 pattern stored", v, 32'hA5C3_0F96);
    rd(2'd2, v); chk("R9 remain follows new start", v, 32'hA5C3_0F96 + ((o % 2 == 0) ? 0 : 1));
    start_count(32'd0, o);
    rd(2'd2, v); chk("R10 remain after second stop", v, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule